// File: doc/BRIEF.md
# Selectable Charge Algorithm Sequencer

This block sequences a lead-acid charger through its fast-charge, termination and maintenance phases once battery qualification has passed. A two-pin strap picks one of three algorithms. The first is a two-step constant-voltage scheme. The second is a two-step constant-current scheme that ends early on a negative voltage-slope trip and then maintains with a fixed-duty pulse. The third is a pulsed-current scheme whose maintenance is hysteretic.

The block takes comparator flags computed elsewhere: battery voltage at or above the bulk level, battery voltage at or below the float level, and sense current at or below the minimum. It also takes a slope-trip flag and a timer tick. From these it drives a regulation-mode code for the power stage, a gate that enables the current or voltage source, and a phase code. A start strobe launches a cycle. An abort returns the block to idle.

Top module: `charge_seq`

## Requirements
- R1: The strap is sampled only when a start is accepted in idle, and that algorithm is held until the block returns to idle. The decode is: `strap_q` low gives two-step voltage (`strap_t` is ignored); `strap_q` high with `strap_t` low gives two-step current; both high gives pulsed current.
- R2: After reset, and whenever the block is idle, `reg_mode` is 0 (off), `phase` is 0 and `pulse_gate` is 0. A `start` seen in idle gives `reg_mode`=1 (current at maximum), `phase`=1 and `pulse_gate`=1 one clock later, for every algorithm.
- R3: In two-step voltage, `v_at_bulk` during phase 1 moves the block one clock later to `phase`=2 with `reg_mode`=2 (voltage at bulk) and the gate high.
- R4: In two-step voltage, `i_at_min` during phase 2 moves the block one clock later to `phase`=3 with `reg_mode`=3 (voltage at float) and the gate high.
- R5: In two-step current, phase 1 ends on `v_at_bulk` or on `slope_trip`. One clock later the block is in `phase`=3 with `reg_mode`=4 (pulsed).
- R6: In two-step current maintenance, `pulse_gate` is high for the first PULSE_ON ticks of every PULSE_PERIOD ticks, counted from entry into maintenance. It is high in the first cycle of maintenance.
- R7: In pulsed current, phase 1 ends only on `v_at_bulk` (one clock later, `phase`=3, `reg_mode`=4). `slope_trip` has no effect.
- R8: In pulsed-current maintenance, `pulse_gate` is low on entry. `v_at_float` sets it one clock later and `v_at_bulk` clears it one clock later. If both flags are high, clearing wins.
- R9: `abort` gives idle one clock later (`reg_mode`=0, `pulse_gate`=0, `phase`=0). It has priority over every other input.
- R10: `start` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a charge cycle |
| abort | input | 1 | Return to idle |
| strap_q | input | 1 | Algorithm strap, select pin |
| strap_t | input | 1 | Algorithm strap, secondary pin |
| v_at_bulk | input | 1 | Battery voltage at or above bulk level |
| v_at_float | input | 1 | Battery voltage at or below float level |
| i_at_min | input | 1 | Sense current at or below minimum |
| slope_trip | input | 1 | Accumulated second difference below threshold |
| tick | input | 1 | Timer tick for the fixed pulse |
| reg_mode | output | 3 | 0 off, 1 current max, 2 voltage bulk, 3 voltage float, 4 pulsed |
| pulse_gate | output | 1 | Source enable |
| phase | output | 2 | 0 idle, 1 fast, 2 bulk voltage, 3 maintenance |

## Verification
The embedded properties check on every cycle that abort always lands in idle with the output off. They also check that a start in idle always yields maximum current, that the current drop in phase 2 always ends it, and that the hysteretic gate follows the float and bulk flags one clock later. Other behaviour only shows in the bench scenarios, which compare against a reference model under random flags and directed cases. This covers the pulse duty and its alignment to entry, the strap being held after a mid-cycle change, slope trips being ignored in pulsed mode, and starts being ignored outside idle.

// File: rtl/charge_seq.sv
module charge_seq #(
  parameter int PULSE_ON     = 2,
  parameter int PULSE_PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       strap_q,
  input  logic       strap_t,
  input  logic       v_at_bulk,
  input  logic       v_at_float,
  input  logic       i_at_min,
  input  logic       slope_trip,
  input  logic       tick,
  output logic [2:0] reg_mode,
  output logic       pulse_gate,
  output logic [1:0] phase
);
  localparam int CW = (PULSE_PERIOD > 2) ? $clog2(PULSE_PERIOD) : 1;
  localparam logic [CW-1:0] ON_C   = CW'(PULSE_ON);
  localparam logic [CW-1:0] LAST_C = CW'(PULSE_PERIOD - 1);

  typedef enum logic [1:0] {S_IDLE, S_FAST, S_BULKV, S_MAINT} st_t;
  typedef enum logic [1:0] {A_VSTEP, A_ISTEP, A_PULSE} alg_t;

  st_t           st;
  alg_t          alg;
  logic [CW-1:0] cnt;
  logic          hyst;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st   <= S_IDLE;
      alg  <= A_VSTEP;
      cnt  <= '0;
      hyst <= 1'b0;
    end else begin
      if (st != S_MAINT) begin
        cnt  <= '0;
        hyst <= 1'b0;
      end else begin
        if (alg == A_ISTEP && tick) cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
        if (alg == A_PULSE) begin
          if (v_at_bulk)       hyst <= 1'b0;
          else if (v_at_float) hyst <= 1'b1;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          st  <= S_FAST;
          alg <= !strap_q ? A_VSTEP : (strap_t ? A_PULSE : A_ISTEP);
        end
        S_FAST: case (alg)
          A_VSTEP: if (v_at_bulk) st <= S_BULKV;
          A_ISTEP: if (v_at_bulk || slope_trip) st <= S_MAINT;
          default: if (v_at_bulk) st <= S_MAINT;
        endcase
        S_BULKV: if (i_at_min) st <= S_MAINT;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_mode   = 3'd0;
    pulse_gate = 1'b0;
    case (st)
      S_FAST:  begin reg_mode = 3'd1; pulse_gate = 1'b1; end
      S_BULKV: begin reg_mode = 3'd2; pulse_gate = 1'b1; end
      S_MAINT: begin
        reg_mode   = (alg == A_VSTEP) ? 3'd3 : 3'd4;
        pulse_gate = (alg == A_VSTEP) ? 1'b1 : (alg == A_ISTEP) ? (cnt < ON_C) : hyst;
      end
      default: ;
    endcase
  end

  assign phase = st;

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (reg_mode == 3'd0 && !pulse_gate && phase == 2'd0));
  p_start_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && start && !abort) |=> (reg_mode == 3'd1 && pulse_gate && phase == 2'd1));
  p_min_current_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && i_at_min && !abort) |=> (phase == 2'd3 && reg_mode == 3'd3));
  p_hyst_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && reg_mode == 3'd4 && alg == A_PULSE && v_at_float && !v_at_bulk && !abort)
      |=> pulse_gate);
  p_hyst_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && alg == A_PULSE && v_at_bulk && !abort) |=> !pulse_gate);
  p_maint_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !abort) |=> phase == 2'd3);
endmodule

// File: tb/charge_seq_tb.sv
module charge_seq_tb;
  localparam int ON = 2, PER = 8;
  logic clk = 0, rst_n = 0;
  logic start = 0, abort = 0, strap_q = 0, strap_t = 0;
  logic v_at_bulk = 0, v_at_float = 0, i_at_min = 0, slope_trip = 0, tick = 0;
  logic [2:0] reg_mode;
  logic pulse_gate;
  logic [1:0] phase;
  int checks = 0, errors = 0;
  int m_st = 0, m_alg = 0, m_cnt = 0, m_hyst = 0;

  always #5 clk = ~clk;

  charge_seq #(.PULSE_ON(ON), .PULSE_PERIOD(PER)) u_dut (.*);

  function automatic int exp_mode();
    case (m_st)
      1: return 1;
      2: return 2;
      3: return (m_alg == 0) ? 3 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_gate();
    if (m_st == 1 || m_st == 2) return 1;
    if (m_st != 3) return 0;
    if (m_alg == 0) return 1;
    if (m_alg == 1) return (m_cnt < ON) ? 1 : 0;
    return m_hyst;
  endfunction

  function automatic string tag_of();
    if (m_st == 0) return "R2";
    if (m_st == 2) return "R4";
    if (m_st == 1) return (m_alg == 0) ? "R3" : (m_alg == 1) ? "R5" : "R7";
    return (m_alg == 0) ? "R4" : (m_alg == 1) ? "R6" : "R8";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic st_i, ab, sq, stt, vb, vf, im, sl, tk);
    start = st_i; abort = ab; strap_q = sq; strap_t = stt;
    v_at_bulk = vb; v_at_float = vf; i_at_min = im; slope_trip = sl; tick = tk;
    if (ab) begin
      m_st = 0; m_cnt = 0; m_hyst = 0;
    end else begin
      if (m_st != 3) begin m_cnt = 0; m_hyst = 0; end
      else begin
        if (m_alg == 1 && tk) m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
        if (m_alg == 2) begin
          if (vb) m_hyst = 0; else if (vf) m_hyst = 1;
        end
      end
      case (m_st)
        0: if (st_i) begin m_st = 1; m_alg = !sq ? 0 : (stt ? 2 : 1); end
        1: if (m_alg == 0) begin if (vb) m_st = 2; end
           else if (m_alg == 1) begin if (vb || sl) m_st = 3; end
           else if (vb) m_st = 3;
        2: if (im) m_st = 3;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag_of(), int'(reg_mode), exp_mode());
    chk(tag_of(), int'(pulse_gate), exp_gate());
    chk(tag_of(), int'(phase), m_st);
  endtask

  task automatic idle1();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset state
    chk("R2", int'(reg_mode), 0); chk("R2", int'(pulse_gate), 0); chk("R2", int'(phase), 0);

    // R1/R3/R4: two-step voltage, strap changed mid-cycle
    step(1, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0, 0, 0, 0);
    chk("R3", int'(reg_mode), 2);
    step(0, 0, 1, 0, 0, 0, 1, 0, 0);
    chk("R1", int'(reg_mode), 3);
    // R10: start in maintenance has no effect
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10", int'(phase), 3);
    // R9: abort
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", int'(reg_mode), 0);

    // R5/R6: two-step current, slope termination, then pulse train
    step(1, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5", int'(reg_mode), 4);
    chk("R6", int'(pulse_gate), 1);
    for (int i = 0; i < 3 * PER; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);

    // R7/R8: pulsed current, slope ignored, hysteresis with both flags
    step(1, 0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7", int'(phase), 1);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8", int'(pulse_gate), 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", int'(pulse_gate), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R8", int'(pulse_gate), 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle1();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 6) == 0, ($urandom % 97) == 0, $urandom % 2, $urandom % 2,
           ($urandom % 9) == 0, ($urandom % 4) == 0, ($urandom % 9) == 0,
           ($urandom % 23) == 0, ($urandom % 3) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule